// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is a counter-based pulse-width modulator that only runs up-down. On each enabled timer tick the counter climbs from zero to a selectable ceiling and then descends back to zero. Two compare channels watch the count and each drives a PWM pin whose polarity is chosen per channel. Because every channel edge falls on a rising or falling slope of the same triangle, the pulses stay centred on the counter's turning point.

The ceiling comes from a 4-bit mode code. It is either a fixed all-ones value of 8, 9 or 10 bits, the capture register, or the active value of compare channel A. Writes to the compare channels land in a shadow buffer and only reach the comparators while the counter sits at the ceiling. A waveform period therefore always starts and ends at the ceiling. Four sticky event flags report ceiling, bottom and compare events, and each is cleared by writing a one to its bit.

Top module: `dspwm_timer`

## Requirements
- R1: After reset the counter reads 0, it counts upward, the compare buffers, active compare values, capture register and all four flags are 0, and both PWM pins are low.
- R2: The ceiling (TOP) is set by `mode`. Code 1 gives 0x00FF, code 2 gives 0x01FF, code 3 gives 0x03FF, code 10 uses the capture register and code 11 uses the active compare A value. Any other code behaves like 0x00FF.
- R3: On each tick while counting upward, the counter adds one until it equals TOP. The tick processed at TOP reverses the direction and subtracts one, so TOP is visible for exactly one tick. On a tick processed at 0 while counting downward, the counter turns upward and moves to 1.
- R4: When `tick` is low the counter, direction, active compare values, waveforms and flag set events do not change. Register writes and flag clears still take effect.
- R5: A compare write goes to that channel's buffer. The active compare value is copied from the buffer only on the tick processed at TOP.
- R6: In modes 1, 2 and 3, a value written to either compare buffer has every bit above the 8-, 9- or 10-bit ceiling width forced to 0.
- R7: Flag bit 3 (bottom) is set by the tick processed at 0 while counting downward.
- R8: Flag bit 2 (capture-TOP) is set by the tick processed at TOP in mode 10. In mode 11 that same tick sets flag bit 0. Both flags are set in the cycle in which the compare buffers are copied.
- R9: Flag bit 0 (channel A) or bit 1 (channel B) is set by any tick on which the counter equals that channel's active compare value.
- R10: On a compare match, output mode 2 (non-inverted) drives the pin low when counting upward and high when counting downward. Output mode 3 (inverted) does the reverse. For output modes 0 and 1 the pin and its enable are both low. For modes 2 and 3 the enable is high.
- R11: Writing 1 to a bit of `flag_clr` clears that flag. A set event in the same cycle wins, and the flag stays 1.
- R12: If a channel's active compare value is above TOP, that channel never matches and its flag is never set.
- R13: With `wr_en` high, `wr_sel` selects the target: 0 loads the counter immediately, 1 writes compare buffer A, 2 writes compare buffer B and 3 writes the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer-clock enable; one count step per high cycle |
| mode | input | 4 | TOP selection code |
| out_mode_a | input | 2 | Output mode of channel A |
| out_mode_b | input | 2 | Output mode of channel B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: counter, buffer A, buffer B, capture |
| wr_data | input | CNT_W | Write data |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| count | output | CNT_W | Current counter value |
| flags | output | 4 | {bottom, capture-TOP, compare B, compare A} |
| pwm_a | output | 1 | Channel A waveform |
| pwm_a_oe | output | 1 | Channel A pin driven by the compare logic |
| pwm_b | output | 1 | Channel B waveform |
| pwm_b_oe | output | 1 | Channel B pin driven by the compare logic |

## Verification
The bench builds the block with its defaults: a 16-bit counter and three fixed ceilings of 8, 9 and 10 bits. Capture-defined ceilings of a few counts keep full up-down periods, ceiling reloads and bottom events to a handful of ticks each. The fixed 8-, 9- and 10-bit ceilings, and the bit masking that goes with them, are reached by preloading the counter just below the turning point.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
   localparam int MODE_W = 4;
   localparam int FLAG_W = 4;

   localparam logic [MODE_W-1:0] MODE_TOP_CAP  = 4'd10;
   localparam logic [MODE_W-1:0] MODE_TOP_CMPA = 4'd11;

   localparam int FLG_CMPA = 0;
   localparam int FLG_CMPB = 1;
   localparam int FLG_CAP  = 2;
   localparam int FLG_BOT  = 3;

   typedef enum logic [1:0] {
      SEL_CNT  = 2'd0,
      SEL_CMPA = 2'd1,
      SEL_CMPB = 2'd2,
      SEL_CAP  = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/dspwm_top_sel.sv
module dspwm_top_sel
   import dspwm_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int FIX_BASE_W = 8,
   parameter int FIX_COUNT  = 3
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [CNT_W-1:0]  cap_val,
   input  logic [CNT_W-1:0]  cmpa_act,
   output logic [CNT_W-1:0]  top,
   output logic [CNT_W-1:0]  wr_mask,
   output logic              top_is_cap,
   output logic              top_is_cmpa
);
   localparam logic [CNT_W-1:0] ONES = '1;
   localparam int SHIFT_BASE = CNT_W - FIX_BASE_W;

   logic [CNT_W-1:0] base_top;
   logic             is_fixed;

   assign base_top = ONES >> SHIFT_BASE;
   assign is_fixed = (int'(mode) >= 1) && (int'(mode) <= FIX_COUNT);

   always_comb begin
      top_is_cap  = (mode == MODE_TOP_CAP);
      top_is_cmpa = (mode == MODE_TOP_CMPA);
      wr_mask     = ONES;
      if (is_fixed) begin
         top     = ONES >> (SHIFT_BASE - int'(mode) + 1);
         wr_mask = top;
      end else if (top_is_cap) begin
         top = cap_val;
      end else if (top_is_cmpa) begin
         top = cmpa_act;
      end else begin
         top = base_top;
      end
   end
endmodule

// File: rtl/dspwm_counter.sv
module dspwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic             at_top,
   output logic             at_bot
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign at_top = tick && up && (cnt >= top);
   assign at_bot = tick && !up && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else begin
         if (at_top) begin
            up <= 1'b0;
            if (cnt != '0) cnt <= cnt - ONE;
         end else if (at_bot) begin
            up <= 1'b1;
            if (top != '0) cnt <= cnt + ONE;
         end else if (tick) begin
            cnt <= up ? cnt + ONE : cnt - ONE;
         end
         if (wr_cnt) cnt <= wr_val;
      end
   end

   // R3
   cnt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && up && (cnt < top) && !wr_cnt) |=> (cnt == $past(cnt) + ONE));

   // R3
   cnt_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && up && (cnt >= top) && (cnt != '0) && !wr_cnt)
         |=> (!up && (cnt == $past(cnt) - ONE)));

   // R4
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_cnt) |=> ($stable(cnt) && $stable(up)));
endmodule

// File: rtl/dspwm_chan.sv
module dspwm_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_top,
   input  logic             up,
   input  logic             inv,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] act,
   output logic             wave,
   output logic             match
);
   logic [CNT_W-1:0] cmp_buf;

   assign match = tick && (cnt == act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf <= '0;
         act     <= '0;
         wave    <= 1'b0;
      end else begin
         if (wr) cmp_buf <= wr_val;
         if (at_top) act <= cmp_buf;
         if (match) wave <= (up ~^ inv);
      end
   end

   // R5
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !at_top |=> $stable(act));

   // R10
   wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match |=> $stable(wave));
endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
   import dspwm_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int FIX_BASE_W = 8,
   parameter int FIX_COUNT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [MODE_W-1:0] mode,
   input  logic [1:0]        out_mode_a,
   input  logic [1:0]        out_mode_b,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [FLAG_W-1:0] flag_clr,
   output logic [CNT_W-1:0]  count,
   output logic [FLAG_W-1:0] flags,
   output logic              pwm_a,
   output logic              pwm_a_oe,
   output logic              pwm_b,
   output logic              pwm_b_oe
);
   localparam int NCH = 2;
   localparam int FIX_MAX_W = FIX_BASE_W + FIX_COUNT - 1;

   initial begin : param_chk
      assert (FIX_BASE_W >= 1 && FIX_COUNT >= 1 && FIX_MAX_W <= CNT_W)
         else $fatal(1, "fixed ceiling widths do not fit the counter");
      assert (FIX_COUNT < int'(MODE_TOP_CAP))
         else $fatal(1, "fixed ceiling codes overlap register codes");
   end

   wr_sel_e          sel;
   logic [CNT_W-1:0] cap_q;
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] wr_mask;
   logic [CNT_W-1:0] masked;
   logic             top_is_cap, top_is_cmpa;
   logic [CNT_W-1:0] cnt;
   logic             up, at_top, at_bot;
   logic [NCH-1:0][CNT_W-1:0] act;
   logic [NCH-1:0][1:0]       omode;
   logic [NCH-1:0]            wave, match, wr_cmp, oe;
   logic [FLAG_W-1:0]         flag_set, flag_q;

   assign sel      = wr_sel_e'(wr_sel);
   assign masked   = wr_data & wr_mask;
   assign omode[0] = out_mode_a;
   assign omode[1] = out_mode_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else if (wr_en && sel == SEL_CAP) cap_q <= wr_data;
   end

   dspwm_top_sel #(
      .CNT_W(CNT_W), .FIX_BASE_W(FIX_BASE_W), .FIX_COUNT(FIX_COUNT)
   ) u_top_sel (
      .mode(mode), .cap_val(cap_q), .cmpa_act(act[0]),
      .top(top), .wr_mask(wr_mask),
      .top_is_cap(top_is_cap), .top_is_cmpa(top_is_cmpa)
   );

   dspwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .top(top),
      .wr_cnt(wr_en && sel == SEL_CNT), .wr_val(wr_data),
      .cnt(cnt), .up(up), .at_top(at_top), .at_bot(at_bot)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      localparam wr_sel_e CH_SEL = (ch == 0) ? SEL_CMPA : SEL_CMPB;
      assign wr_cmp[ch] = wr_en && (sel == CH_SEL);
      assign oe[ch]     = omode[ch][1];
      dspwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
         .up(up), .inv(omode[ch][0]), .cnt(cnt),
         .wr(wr_cmp[ch]), .wr_val(masked),
         .act(act[ch]), .wave(wave[ch]), .match(match[ch])
      );
   end

   always_comb begin
      flag_set           = '0;
      flag_set[FLG_CMPA] = match[0] || (at_top && top_is_cmpa);
      flag_set[FLG_CMPB] = match[1];
      flag_set[FLG_CAP]  = at_top && top_is_cap;
      flag_set[FLG_BOT]  = at_bot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | flag_set;
   end

   for (genvar f = 0; f < FLAG_W; f++) begin : g_flag_chk
      // R11
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_clr[f] && !flag_set[f]) |=> !flag_q[f]);
      // R11
      flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag_set[f] |=> flag_q[f]);
   end

   // R7
   bot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !up && cnt == '0) |=> (flag_q[FLG_BOT] && up));

   assign count    = cnt;
   assign flags    = flag_q;
   assign pwm_a    = oe[0] & wave[0];
   assign pwm_b    = oe[1] & wave[1];
   assign pwm_a_oe = oe[0];
   assign pwm_b_oe = oe[1];
endmodule

// File: tb/test_dspwm_timer.sv
`timescale 1ns/1ps
module test_dspwm_timer;
   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n;
   logic         tick;
   logic [3:0]   mode;
   logic [1:0]   out_mode_a, out_mode_b;
   logic         wr_en;
   logic [1:0]   wr_sel;
   logic [W-1:0] wr_data;
   logic [3:0]   flag_clr;
   logic [W-1:0] count;
   logic [3:0]   flags;
   logic         pwm_a, pwm_a_oe, pwm_b, pwm_b_oe;

   dspwm_timer i_dspwm_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
      .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
      .count(count), .flags(flags), .pwm_a(pwm_a), .pwm_a_oe(pwm_a_oe),
      .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state, derived from the requirements
   logic [W-1:0] m_cnt, m_cap;
   logic         m_up;
   logic [W-1:0] m_buf [2];
   logic [W-1:0] m_act [2];
   logic [1:0]   m_out;
   logic [3:0]   m_flags;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_model(string req);
      chk(req, "count", 32'(count), 32'(m_cnt));
      chk(req, "flags", 32'(flags), 32'(m_flags));
      chk(req, "pwm_a", 32'(pwm_a), 32'(out_mode_a[1] & m_out[0]));
      chk(req, "pwm_b", 32'(pwm_b), 32'(out_mode_b[1] & m_out[1]));
      chk(req, "pwm_a_oe", 32'(pwm_a_oe), 32'(out_mode_a[1]));
      chk(req, "pwm_b_oe", 32'(pwm_b_oe), 32'(out_mode_b[1]));
   endtask

   task automatic model_init();
      m_cnt = '0; m_cap = '0; m_up = 1'b1; m_out = '0; m_flags = '0;
      for (int i = 0; i < 2; i++) begin m_buf[i] = '0; m_act[i] = '0; end
   endtask

   // one clock cycle; entered and left at a falling edge
   task automatic step(string req, logic tk, logic we, logic [1:0] sel,
                       logic [W-1:0] d, logic [3:0] clr);
      logic [W-1:0] top, msk, n_cnt;
      logic         at_top, at_bot, n_up;
      logic [1:0]   mt;
      logic [3:0]   set;
      tick = tk; wr_en = we; wr_sel = sel; wr_data = d; flag_clr = clr;
      case (mode)
         4'd1:    begin top = 16'h00FF; msk = 16'h00FF; end
         4'd2:    begin top = 16'h01FF; msk = 16'h01FF; end
         4'd3:    begin top = 16'h03FF; msk = 16'h03FF; end
         4'd10:   begin top = m_cap;    msk = 16'hFFFF; end
         4'd11:   begin top = m_act[0]; msk = 16'hFFFF; end
         default: begin top = 16'h00FF; msk = 16'hFFFF; end
      endcase
      at_top = tk && m_up && (m_cnt >= top);
      at_bot = tk && !m_up && (m_cnt == 0);
      mt[0]  = tk && (m_cnt == m_act[0]);
      mt[1]  = tk && (m_cnt == m_act[1]);
      set = {at_bot, at_top && mode == 4'd10, mt[1], mt[0] || (at_top && mode == 4'd11)};
      n_cnt = m_cnt; n_up = m_up;
      if (at_top) begin n_up = 1'b0; if (m_cnt != 0) n_cnt = m_cnt - 1; end
      else if (at_bot) begin n_up = 1'b1; if (top != 0) n_cnt = m_cnt + 1; end
      else if (tk) n_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
      @(posedge clk);
      @(negedge clk);
      m_flags = (m_flags & ~clr) | set;
      if (mt[0]) m_out[0] = m_up ? out_mode_a[0] : ~out_mode_a[0];
      if (mt[1]) m_out[1] = m_up ? out_mode_b[0] : ~out_mode_b[0];
      if (at_top) begin m_act[0] = m_buf[0]; m_act[1] = m_buf[1]; end
      m_cnt = n_cnt; m_up = n_up;
      if (we) begin
         case (sel)
            2'd0: m_cnt = d;
            2'd1: m_buf[0] = d & msk;
            2'd2: m_buf[1] = d & msk;
            default: m_cap = d;
         endcase
      end
      tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; flag_clr = '0;
      compare_model(req);
   endtask

   task automatic ticks(string req, int n);
      for (int i = 0; i < n; i++) step(req, 1'b1, 1'b0, 2'd0, '0, 4'h0);
   endtask

   task automatic wr(string req, logic [1:0] sel, logic [W-1:0] d);
      step(req, 1'b0, 1'b1, sel, d, 4'h0);
   endtask

   task automatic clr_flags(string req, logic [3:0] m);
      step(req, 1'b0, 1'b0, 2'd0, '0, m);
   endtask

   task automatic do_reset(logic [3:0] md, logic [1:0] oa, logic [1:0] ob);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      flag_clr = '0; mode = md; out_mode_a = oa; out_mode_b = ob;
      model_init();
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(4'd10, 2'd2, 2'd3);
      chk("R1", "count", 32'(count), 0);
      chk("R1", "flags", 32'(flags), 0);
      chk("R1", "pwm_a", 32'(pwm_a), 0);
      chk("R1", "pwm_b", 32'(pwm_b), 0);
   endtask

   task automatic t_count();
      int seq [11] = '{1, 2, 3, 4, 5, 4, 3, 2, 1, 0, 1};
      do_reset(4'd10, 2'd0, 2'd0);
      wr("R13", 2'd3, 16'd5);
      clr_flags("R11", 4'hF);
      for (int i = 0; i < 11; i++) begin
         ticks("R3", 1);
         chk("R3", "count sequence", 32'(count), 32'(seq[i]));
         if (i == 5) chk("R8", "capture-TOP flag at TOP", 32'(flags[2]), 1);
         if (i == 9) chk("R7", "bottom flag before bottom tick", 32'(flags[3]), 0);
         if (i == 10) chk("R7", "bottom flag after bottom tick", 32'(flags[3]), 1);
      end
   endtask

   task automatic t_hold();
      do_reset(4'd10, 2'd2, 2'd2);
      wr("R13", 2'd3, 16'd9);
      wr("R13", 2'd0, 16'd3);
      chk("R13", "counter load", 32'(count), 3);
      for (int i = 0; i < 4; i++) step("R4", 1'b0, 1'b0, 2'd0, '0, 4'h0);
      chk("R4", "count held without tick", 32'(count), 3);
      wr("R4", 2'd0, 16'd7);
      chk("R4", "write applies without tick", 32'(count), 7);
      ticks("R4", 1);
      chk("R4", "count resumes", 32'(count), 8);
   endtask

   task automatic t_pwm();
      do_reset(4'd10, 2'd2, 2'd3);
      wr("R13", 2'd3, 16'd8);
      wr("R5", 2'd1, 16'd3);
      wr("R5", 2'd2, 16'd5);
      ticks("R9", 1);
      chk("R9", "flags after match at 0", 32'(flags[1:0]), 3);
      chk("R10", "inverted pin high after up match", 32'(pwm_b), 1);
      clr_flags("R11", 4'hF);
      ticks("R5", 3);
      chk("R5", "buffered value not yet active", 32'(flags[0]), 0);
      ticks("R5", 5);
      chk("R8", "capture-TOP flag", 32'(flags[2]), 1);
      chk("R3", "turned at TOP", 32'(count), 7);
      ticks("R10", 4);
      chk("R10", "inverted pin low after down match", 32'(pwm_b), 0);
      ticks("R10", 1);
      chk("R10", "non-inverted pin high after down match", 32'(pwm_a), 1);
      chk("R9", "channel A flag", 32'(flags[0]), 1);
      wr("R5", 2'd1, 16'd6);
      ticks("R10", 30);
      wr("R12", 2'd3, 16'd4);
      ticks("R12", 20);
      out_mode_a = 2'd1;
      ticks("R10", 6);
      chk("R10", "mode 1 pin low", 32'(pwm_a), 0);
      chk("R10", "mode 1 pin undriven", 32'(pwm_a_oe), 0);
      out_mode_b = 2'd0;
      ticks("R10", 6);
      chk("R10", "mode 0 pin undriven", 32'(pwm_b_oe), 0);
   endtask

   task automatic t_mask();
      do_reset(4'd1, 2'd2, 2'd0);
      wr("R6", 2'd1, 16'h01F0);
      wr("R6", 2'd0, 16'h00FF);
      ticks("R2", 1);
      chk("R2", "8-bit ceiling turn", 32'(count), 32'h00FE);
      clr_flags("R6", 4'hF);
      wr("R6", 2'd0, 16'h00F0);
      ticks("R6", 1);
      chk("R6", "masked compare matches", 32'(flags), 32'h1);
      chk("R6", "pin set on down match", 32'(pwm_a), 1);
   endtask

   task automatic t_fixed();
      do_reset(4'd3, 2'd0, 2'd0);
      wr("R2", 2'd0, 16'h03FD);
      ticks("R2", 1);
      chk("R2", "10-bit ceiling climb", 32'(count), 32'h03FE);
      ticks("R2", 1);
      chk("R2", "10-bit ceiling reached", 32'(count), 32'h03FF);
      ticks("R2", 1);
      chk("R2", "10-bit ceiling turn", 32'(count), 32'h03FE);
      mode = 4'd2;
      wr("R2", 2'd0, 16'h01FF);
      step("R2", 1'b1, 1'b0, 2'd0, '0, 4'h0);
      chk("R2", "9-bit ceiling downward", 32'(count), 32'h01FE);
      mode = 4'd7;
      wr("R2", 2'd0, 16'h0020);
      ticks("R2", 40);
   endtask

   task automatic t_mode11();
      do_reset(4'd11, 2'd2, 2'd0);
      wr("R2", 2'd1, 16'd4);
      ticks("R8", 5);
      chk("R2", "climb toward compare A ceiling", 32'(count), 4);
      clr_flags("R8", 4'hF);
      ticks("R8", 1);
      chk("R8", "compare A flag at TOP in mode 11", 32'(flags[0]), 1);
      chk("R8", "no capture flag in mode 11", 32'(flags[2]), 0);
      chk("R2", "turn at compare A ceiling", 32'(count), 3);
   endtask

   task automatic t_w1c();
      do_reset(4'd10, 2'd0, 2'd0);
      wr("R13", 2'd3, 16'd3);
      ticks("R11", 3);
      step("R11", 1'b1, 1'b0, 2'd0, '0, 4'b0100);
      chk("R11", "set wins over clear", 32'(flags[2]), 1);
      clr_flags("R11", 4'b0100);
      chk("R11", "cleared bit", 32'(flags[2]), 0);
      chk("R11", "other flag untouched", 32'(flags[0]), 1);
   endtask

   task automatic t_notop();
      do_reset(4'd10, 2'd0, 2'd2);
      wr("R13", 2'd3, 16'd4);
      wr("R12", 2'd2, 16'd6);
      ticks("R12", 1);
      clr_flags("R12", 4'hF);
      ticks("R12", 16);
      chk("R12", "compare above TOP never matches", 32'(flags[1]), 0);
      chk("R12", "pin never set", 32'(pwm_b), 0);
   endtask

   initial begin
      t_reset();
      t_count();
      t_hold();
      t_pwm();
      t_mask();
      t_fixed();
      t_mode11();
      t_w1c();
      t_notop();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule